// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses, once per clock, the address of the next microinstruction in a microprogrammed control unit. It holds a control address register, which drives the control memory directly, and a one-entry return register for a single level of micro-subroutine. The control memory sits outside the block and is read combinationally. It returns three fields to the sequencer: a 2-bit condition selector, a 2-bit branch kind and a branch target. The sequencer combines these with three processor status bits and the 4-bit operation code of the current machine instruction.

Each clock edge loads the address register from one of four sources. The sources are the address plus one, the branch target, the saved return address, and an address derived from the operation code. The derived address places each machine instruction's routine in its own four-word slot in the lower half of the control memory. The upper half holds the fetch routine, which starts at address 64. Only the address register and the return register are clocked. Source selection, condition testing and operation-code mapping are all combinational.

Top module: `microseq_top`

## Requirements
- R1: Reset loads the address output with 64 and clears the return register, so a return issued as the first microinstruction after reset yields address 0.
- R2: The condition selector picks the tested bit: 00 is always true, 01 tests indBit, 10 tests signBit, 11 tests zeroBit. The condition holds when the selected bit is 1.
- R3: Branch kind 00 (jump) loads the branch target when the condition holds; otherwise the address increments by one.
- R4: Branch kind 01 (call) with the condition true loads the branch target and stores the current address plus one in the return register.
- R5: A call whose condition is false increments the address and leaves the return register unchanged.
- R6: Branch kind 10 (return) loads the return register into the address, regardless of the condition selector and the branch target.
- R7: Branch kind 11 (map) loads bit 6 = 0, bits 5..2 = opcode and bits 1..0 = 00, regardless of the condition selector and the branch target.
- R8: Incrementing from address 127 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| condSel | input | 2 | Condition selector field of the current microinstruction |
| brKind | input | 2 | Branch kind field of the current microinstruction |
| brTarget | input | 7 | Branch target field of the current microinstruction |
| indBit | input | 1 | Indirect-address status bit |
| signBit | input | 1 | Accumulator sign status bit |
| zeroBit | input | 1 | Accumulator-is-zero status bit |
| opcode | input | 4 | Operation code of the current machine instruction |
| ctlAddr | output | 7 | Control memory address (the control address register) |

## Verification
A jump is tried with each of the four condition selectors, once with the tested bit low and once with it high. This shows that each code selects its own status bit and that a false condition falls through to the increment. Calls are tried both taken and not taken, each followed by a return. The value returned shows whether the return register was written only on a taken call. Return and map are issued with the condition selector and target set to misleading values, which exposes any dependence on those fields. A short microprogram from a small test memory then runs fetch, map, a conditional call into an indirect subroutine, a return, and a jump back to fetch.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
  typedef enum logic [1:0] {
    SRC_INC = 2'b00,
    SRC_AD  = 2'b01,
    SRC_SBR = 2'b10,
    SRC_MAP = 2'b11
  } srcSel_e;

  typedef struct packed {
    srcSel_e srcSel;
    logic    saveRet;
  } seqStrobe_t;

  localparam logic [1:0] BR_JUMP = 2'b00;
  localparam logic [1:0] BR_CALL = 2'b01;
  localparam logic [1:0] BR_RET  = 2'b10;
  localparam logic [1:0] BR_MAP  = 2'b11;
endpackage

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
  import microseq_pkg::*;
(
  input  logic [1:0] condSel,
  input  logic [1:0] brKind,
  input  logic       indBit,
  input  logic       signBit,
  input  logic       zeroBit,
  output seqStrobe_t strobe
);
  logic [3:0] condVec;
  logic       testHit;

  // condition multiplexer: index 0 is the constant-true input
  assign condVec = {zeroBit, signBit, indBit, 1'b1};
  assign testHit = condVec[condSel];

  always_comb begin
    strobe.saveRet = 1'b0;
    strobe.srcSel  = SRC_INC;
    unique case (brKind)
      BR_JUMP: strobe.srcSel = testHit ? SRC_AD : SRC_INC;
      BR_CALL: begin
        strobe.srcSel  = testHit ? SRC_AD : SRC_INC;
        strobe.saveRet = testHit;
      end
      BR_RET:  strobe.srcSel = SRC_SBR;
      default: strobe.srcSel = SRC_MAP;
    endcase
  end
endmodule

// File: rtl/microseq_dpath.sv
module microseq_dpath
  import microseq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] carQ,
  output logic [ADDR_W-1:0] sbrQ
);
  localparam int SLOT_W = ADDR_W - 1 - OPC_W;
  localparam logic [ADDR_W-1:0] FETCH_BASE = ADDR_W'(1) << (ADDR_W - 1);

  logic [ADDR_W-1:0] carInc;
  logic [ADDR_W-1:0] mapped;
  logic [ADDR_W-1:0] carNext;

  assign carInc = carQ + 1'b1;

  generate
    if (SLOT_W > 0) begin : g_slot
      assign mapped = {1'b0, opcode, {SLOT_W{1'b0}}};
    end else begin : g_noslot
      assign mapped = {1'b0, opcode};
    end
  endgenerate

  always_comb begin
    unique case (strobe.srcSel)
      SRC_INC: carNext = carInc;
      SRC_AD:  carNext = brTarget;
      SRC_SBR: carNext = sbrQ;
      default: carNext = mapped;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carQ <= FETCH_BASE;
      sbrQ <= '0;
    end else begin
      carQ <= carNext;
      if (strobe.saveRet) sbrQ <= carInc;
    end
  end
endmodule

// File: rtl/microseq_top.sv
module microseq_top
  import microseq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        condSel,
  input  logic [1:0]        brKind,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              indBit,
  input  logic              signBit,
  input  logic              zeroBit,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] ctlAddr
);
  seqStrobe_t        strobe;
  logic [ADDR_W-1:0] retAddr;

  microseq_ctrl ctrl_i (
    .condSel(condSel), .brKind(brKind), .indBit(indBit),
    .signBit(signBit), .zeroBit(zeroBit), .strobe(strobe)
  );

  microseq_dpath #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .brTarget(brTarget),
    .opcode(opcode), .carQ(ctlAddr), .sbrQ(retAddr)
  );
endmodule

// File: rtl/microseq_chk.sv
module microseq_chk #(
  parameter int ADDR_W = 7,
  parameter int OPC_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        condSel,
  input logic [1:0]        brKind,
  input logic [ADDR_W-1:0] brTarget,
  input logic              indBit,
  input logic              signBit,
  input logic              zeroBit,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] ctlAddr,
  input logic [ADDR_W-1:0] retAddr
);
  logic              condTrue;
  logic [ADDR_W-1:0] addrPlus;

  always_comb begin
    case (condSel)
      2'b00:   condTrue = 1'b1;
      2'b01:   condTrue = indBit;
      2'b10:   condTrue = signBit;
      default: condTrue = zeroBit;
    endcase
  end
  assign addrPlus = ctlAddr + 1'b1;

  // R3 / R2
  a_r3_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (brKind == 2'b00 && condTrue) |=> ctlAddr == $past(brTarget));

  // R3 / R5 / R8
  a_r3_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (brKind[1] == 1'b0 && !condTrue) |=> ctlAddr == $past(addrPlus));

  a_r4_call_saves: assert property (@(posedge clk) disable iff (rst)
    (brKind == 2'b01 && condTrue) |=> retAddr == $past(addrPlus));

  a_r5_call_skip_keeps: assert property (@(posedge clk) disable iff (rst)
    (brKind == 2'b01 && !condTrue) |=> $stable(retAddr));

  a_r6_return_loads: assert property (@(posedge clk) disable iff (rst)
    (brKind == 2'b10) |=> ctlAddr == $past(retAddr));

  a_r7_map_addr: assert property (@(posedge clk) disable iff (rst)
    (brKind == 2'b11) |=> ctlAddr == {1'b0, $past(opcode), {(ADDR_W-1-OPC_W){1'b0}}});
endmodule

bind microseq_top microseq_chk #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) chk_i (
  .clk(clk), .rst(rst), .condSel(condSel), .brKind(brKind),
  .brTarget(brTarget), .indBit(indBit), .signBit(signBit),
  .zeroBit(zeroBit), .opcode(opcode), .ctlAddr(ctlAddr), .retAddr(retAddr)
);

// File: tb/microseq_top_tb_top.sv
module microseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    condSel = '0;
  logic [1:0]    brKind = '0;
  logic [AW-1:0] brTarget = '0;
  logic          indBit = 1'b0;
  logic          signBit = 1'b0;
  logic          zeroBit = 1'b0;
  logic [3:0]    opcode = '0;
  logic [AW-1:0] ctlAddr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [AW-1:0] expQ[$];
  string         tagQ[$];
  logic [AW-1:0] mCar;
  logic [AW-1:0] mSbr;

  always #(CLK_PERIOD/2) clk = ~clk;

  microseq_top dut_i (
    .clk(clk), .rst(rst), .condSel(condSel), .brKind(brKind),
    .brTarget(brTarget), .indBit(indBit), .signBit(signBit),
    .zeroBit(zeroBit), .opcode(opcode), .ctlAddr(ctlAddr)
  );

  task automatic checkVal(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bench model from the requirements (R2..R8)
  task automatic drive(input logic [1:0] cd, input logic [1:0] br,
                       input logic [AW-1:0] ad, input logic i, input logic s,
                       input logic z, input logic [3:0] op, input string tag);
    logic cond;
    logic [AW-1:0] inc;
    @(negedge clk);
    condSel = cd; brKind = br; brTarget = ad;
    indBit = i; signBit = s; zeroBit = z; opcode = op;
    cond = (cd == 2'b00) ? 1'b1 : (cd == 2'b01) ? i : (cd == 2'b10) ? s : z;
    inc = mCar + 1'b1;
    case (br)
      2'b00: mCar = cond ? ad : inc;
      2'b01: begin
        if (cond) mSbr = inc;
        mCar = cond ? ad : inc;
      end
      2'b10: mCar = mSbr;
      default: mCar = {1'b0, op, 2'b00};
    endcase
    expQ.push_back(mCar);
    tagQ.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) checkVal(tagQ.pop_front(), ctlAddr, expQ.pop_front());
    end
  end

  // small test control memory: {cd, br, ad}
  function automatic logic [10:0] testRom(input logic [AW-1:0] a);
    case (a)
      7'd64:   testRom = {2'b00, 2'b00, 7'd65};
      7'd65:   testRom = {2'b00, 2'b00, 7'd66};
      7'd66:   testRom = {2'b00, 2'b11, 7'd0};
      7'd0:    testRom = {2'b01, 2'b01, 7'd67};
      7'd1:    testRom = {2'b00, 2'b00, 7'd2};
      7'd2:    testRom = {2'b00, 2'b00, 7'd64};
      7'd67:   testRom = {2'b00, 2'b00, 7'd68};
      7'd68:   testRom = {2'b00, 2'b10, 7'd0};
      default: testRom = {2'b00, 2'b00, 7'd64};
    endcase
  endfunction

  initial begin
    mCar = 7'd64;
    mSbr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkVal("R1 reset address", ctlAddr, 7'd64);
    drive(2'b11, 2'b10, 7'd85, 1'b0, 1'b0, 1'b0, 4'h0, "R1 cleared return reg / R6");
    drive(2'b00, 2'b00, 7'd10, 1'b0, 1'b0, 1'b0, 4'h0, "R2 R3 jump always");
    drive(2'b01, 2'b00, 7'd90, 1'b0, 1'b1, 1'b1, 4'h0, "R2 R3 jump I=0");
    drive(2'b01, 2'b00, 7'd20, 1'b1, 1'b0, 1'b0, 4'h0, "R2 R3 jump I=1");
    drive(2'b10, 2'b00, 7'd90, 1'b1, 1'b0, 1'b1, 4'h0, "R2 R3 jump S=0");
    drive(2'b10, 2'b00, 7'd30, 1'b0, 1'b1, 1'b0, 4'h0, "R2 R3 jump S=1");
    drive(2'b11, 2'b00, 7'd90, 1'b1, 1'b1, 1'b0, 4'h0, "R2 R3 jump Z=0");
    drive(2'b11, 2'b00, 7'd40, 1'b0, 1'b0, 1'b1, 4'h0, "R2 R3 jump Z=1");
    drive(2'b00, 2'b01, 7'd50, 1'b0, 1'b0, 1'b0, 4'h0, "R4 call taken");
    drive(2'b01, 2'b10, 7'd99, 1'b0, 1'b0, 1'b0, 4'h0, "R4 R6 return to saved");
    drive(2'b10, 2'b01, 7'd77, 1'b0, 1'b0, 1'b0, 4'h0, "R5 call not taken");
    drive(2'b00, 2'b00, 7'd100, 1'b0, 1'b0, 1'b0, 4'h0, "R3 jump away");
    drive(2'b10, 2'b10, 7'd5, 1'b1, 1'b1, 1'b1, 4'h0, "R5 R6 return reg unchanged");
    drive(2'b01, 2'b11, 7'd33, 1'b0, 1'b0, 1'b0, 4'hF, "R7 map opcode F");
    drive(2'b00, 2'b11, 7'd1, 1'b1, 1'b1, 1'b1, 4'h5, "R7 map opcode 5");
    drive(2'b00, 2'b00, 7'd127, 1'b0, 1'b0, 1'b0, 4'h0, "R3 jump to 127");
    drive(2'b01, 2'b00, 7'd9, 1'b0, 1'b0, 1'b0, 4'h0, "R8 wrap to 0");
    drive(2'b00, 2'b00, 7'd64, 1'b0, 1'b0, 1'b0, 4'h0, "R3 back to fetch");
    // microprogram run: fetch, map ADD, indirect call, return, back to fetch
    for (int k = 0; k < 9; k++) begin
      logic [10:0] w;
      w = testRom(mCar);
      drive(w[10:9], w[8:7], w[6:0], 1'b1, 1'b0, 1'b0, 4'h0, "R3 R4 R6 R7 program run");
    end
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule